// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial shift engine of an SPI master. It pops 32-bit command words from a transmit queue through a valid/ready handshake. Each word carries up to 16 bits of right-justified payload together with its own framing controls: the frame width, which slave selects to drive low, whether the selects are released once the frame ends, and whether an idle gap follows the frame. The engine drives the serial clock, the serial data output and the active-low selects, and it samples the serial data input. Every finished frame is offered to a receive queue as one right-justified item.

Clock polarity, clock phase, bit order and an internal loopback path come from static configuration inputs. The serial bit rate is set by a 16-bit divider of the block clock. A chip integrates it between a transmit and a receive FIFO. Because select release is a per-word flag, software can chain several words into one long select-low transaction. If the transmit queue runs dry in the middle of such a transaction, the engine simply waits with the selects held.

Top module: `spim_frame_engine`

## Requirements
- R1: The command word is decoded as follows. Payload is bits [15:0]. The select mask is bits [23:16], of which the low NUM_SEL bits are used. Bit 24 is the release flag and bit 25 is the gap flag. The width field is bits [31:28] and holds the frame width minus one, so values 0..15 give 1..16 bits. Bits 27:26 and any mask bits at or above NUM_SEL are ignored.
- R2: Each bit lasts P = clk_div+1 block-clock cycles, and P is never less than 2. Consecutive sampling moments inside a frame are exactly P cycles apart.
- R3: While no frame is shifting, sck rests at cfg_cpol. With cfg_cpha=0 the input is sampled on the first sck edge of each bit. With cfg_cpha=1 it is sampled on the second edge. mosi changes only at bit boundaries.
- R4: With cfg_lsb_first=0, mosi sends payload bits from bit W-1 down to bit 0, where W is the frame width. With cfg_lsb_first=1 the order is reversed. Payload bits at or above W are never sent.
- R5: Received bits are placed at the same positions as the transmitted bits they pair with, and bits at or above W are zero. Each frame gives exactly one rx_valid cycle, in the last cycle of its last bit.
- R6: With cfg_loopback=1, the received item equals the transmitted payload masked to W bits, and miso has no effect.
- R7: During a frame, ss_n equals the word's mask, where a 0 bit drives that select low. When the release flag is set, ss_n returns to all ones after the frame. When it is clear, ss_n keeps its value, with sck at cfg_cpol, until the next word is popped, however long that takes.
- R8: A set gap flag holds the engine idle for P extra cycles after the frame, before the release and before the next pop.
- R9: If rx_ready is low in the rx_valid cycle, rx_overrun pulses for that one cycle and the item is lost. Later frames are delivered normally.
- R10: While enable is low, ss_n is all ones, sck is at cfg_cpol and tx_ready is low. A frame in flight is abandoned and yields no receive item.
- R11: tx_ready is high only while the engine is enabled and idle. It is low in the cycle after a word is popped and stays low until the frame and any gap have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable; low forces selects high and abandons any frame |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge of a bit, 1: on second edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_loopback | input | 1 | 1: receive path takes the outgoing data instead of miso |
| clk_div | input | 16 | Bit period minus one, in block-clock cycles |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_ready | output | 1 | Engine pops the word this cycle |
| tx_word | input | 32 | Command word (payload and frame controls) |
| rx_valid | output | 1 | Received item offered this cycle |
| rx_ready | input | 1 | Receive queue can accept an item |
| rx_data | output | 16 | Received item, right-justified |
| rx_overrun | output | 1 | One-cycle pulse when an item is lost to a full receive queue |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SEL | Active-low slave selects |

## Verification
The end of a frame's last bit can coincide with a receive queue that cannot take the item. In that cycle the push and the loss report must not both fire. The bench provokes this by holding rx_ready low across a whole frame. It then judges the result by one counted overrun pulse, an unchanged receive count, and a correct delivery of the frame that follows. A second collision, between the release of a held select and the pop of the next word, is provoked by chaining a word without the release flag to one with it. The bench judges this by the select value seen at every sampling edge of both frames.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the SPI master frame engine.
// Holds the command-word field positions, which a queue writer must match,
// and the engine state encoding.
package spim_pkg;
    localparam int DATA_W      = 16;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 4;
    localparam int SEL_FIELD_W = 8;
    localparam int SEL_LSB     = 16;
    localparam int RELEASE_POS = 24;
    localparam int GAP_POS     = 25;
    localparam int RSVD_LSB    = 26;
    localparam int RSVD_MSB    = 27;
    localparam int LEN_LSB     = 28;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spim_word_decode.sv
`timescale 1ns/1ps
// Splits a transmit command word into payload and frame controls.
// Assumes NUM_SEL is at most SEL_FIELD_W. Reserved bits and mask bits
// above NUM_SEL are dropped.
module spim_word_decode
    import spim_pkg::*;
#(
    parameter int NUM_SEL = 4
) (
    input  logic [WORD_W-1:0]  word,
    output logic [DATA_W-1:0]  payload,
    output logic [LEN_W-1:0]   width_m1,
    output logic               release_sel,
    output logic               gap_after,
    output logic [NUM_SEL-1:0] sel_mask
);
    logic unused_hi;
    logic unused_rsvd;

    // Field extraction at fixed positions
    assign payload     = word[DATA_W-1:0];
    assign width_m1    = word[LEN_LSB +: LEN_W];
    assign release_sel = word[RELEASE_POS];
    assign gap_after   = word[GAP_POS];
    assign sel_mask    = word[SEL_LSB +: NUM_SEL];
    assign unused_rsvd = ^word[RSVD_MSB:RSVD_LSB];

    // Upper mask bits exist only when fewer selects are built than the field holds
    generate
        if (NUM_SEL < SEL_FIELD_W) begin : g_mask_spare
            assign unused_hi = ^word[SEL_LSB+SEL_FIELD_W-1 : SEL_LSB+NUM_SEL];
        end else begin : g_mask_full
            assign unused_hi = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/spim_bit_timer.sv
`timescale 1ns/1ps
// Bit-period timer. While run is high it counts one bit period of
// P = div+1 cycles (at least 2) and repeats. The first half lasts
// ceil(P/2) cycles. It flags the last cycle of the first half and the
// last cycle of the period. Assumes div is static while run is high.
module spim_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             first_half,
    output logic             sample_now,
    output logic             period_end
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half_a;
    logic [CNT_W-1:0] cnt_q;

    // Period length with a floor of two cycles, and its leading half
    always_comb begin
        period = {1'b0, div} + CNT_W'(1);
        if (period < CNT_W'(2)) begin
            period = CNT_W'(2);
        end
        half_a = period - (period >> 1);
    end

    // Position inside the current bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || period_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign first_half = (cnt_q < half_a);
    assign sample_now = run && (cnt_q == half_a - CNT_W'(1));
    assign period_end = run && (cnt_q == period - CNT_W'(1));
endmodule

// File: rtl/spim_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer. It pops one command word when idle, shifts the
// frame bit by bit on the timer strobes, offers the received item at the
// end of the last bit, and then applies the gap and the select release.
// Assumes the configuration is static while a frame is in flight.
module spim_frame_ctrl
    import spim_pkg::*;
#(
    parameter int NUM_SEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_lsb_first,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [DATA_W-1:0]  cmd_payload,
    input  logic [LEN_W-1:0]   cmd_width_m1,
    input  logic               cmd_release,
    input  logic               cmd_gap,
    input  logic [NUM_SEL-1:0] cmd_sel_mask,
    input  logic               sample_now,
    input  logic               period_end,
    input  logic               rx_bit_in,
    output logic               run,
    output logic               shifting,
    output logic               tx_bit,
    output logic [NUM_SEL-1:0] sel_q,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_overrun
);
    eng_state_t         state_q;
    logic [DATA_W-1:0]  txd_q;
    logic [DATA_W-1:0]  rxd_q;
    logic [LEN_W-1:0]   width_q;
    logic [LEN_W-1:0]   bit_q;
    logic               release_q;
    logic               gap_q;
    logic [LEN_W-1:0]   pos;
    logic               last_bit;
    logic               frame_done;

    // Payload position of the current bit for the selected order
    assign pos        = cfg_lsb_first ? bit_q : (width_q - bit_q);
    assign last_bit   = (bit_q == width_q);
    assign frame_done = (state_q == ST_SHIFT) && period_end && last_bit;

    assign tx_ready   = enable && (state_q == ST_IDLE);
    assign run        = (state_q != ST_IDLE);
    assign shifting   = (state_q == ST_SHIFT);
    assign tx_bit     = shifting ? txd_q[pos] : 1'b0;
    assign rx_valid   = frame_done;
    assign rx_data    = rxd_q;
    assign rx_overrun = frame_done && !rx_ready;

    // Frame sequencing, shift registers and select hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            txd_q     <= '0;
            rxd_q     <= '0;
            width_q   <= '0;
            bit_q     <= '0;
            release_q <= 1'b0;
            gap_q     <= 1'b0;
            sel_q     <= '1;
        end else if (!enable) begin
            state_q <= ST_IDLE;
            sel_q   <= '1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (tx_valid) begin
                        txd_q     <= cmd_payload;
                        rxd_q     <= '0;
                        width_q   <= cmd_width_m1;
                        bit_q     <= '0;
                        release_q <= cmd_release;
                        gap_q     <= cmd_gap;
                        sel_q     <= cmd_sel_mask;
                        state_q   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sample_now) begin
                        rxd_q[pos] <= rx_bit_in;
                    end
                    if (period_end) begin
                        if (!last_bit) begin
                            bit_q <= bit_q + LEN_W'(1);
                        end else if (gap_q) begin
                            state_q <= ST_GAP;
                        end else begin
                            state_q <= ST_IDLE;
                            if (release_q) begin
                                sel_q <= '1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (period_end) begin
                        state_q <= ST_IDLE;
                        if (release_q) begin
                            sel_q <= '1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spim_frame_engine.sv
`timescale 1ns/1ps
// SPI master frame engine top. It decodes queued command words, times
// the bits, forms the serial clock from the timer phase and the mode
// inputs, applies the loopback path, and gates the selects with enable.
// Assumes the configuration inputs and clk_div change only while idle.
module spim_frame_engine
    import spim_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int DIV_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               cfg_lsb_first,
    input  logic               cfg_loopback,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [WORD_W-1:0]  tx_word,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_overrun,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_SEL-1:0] ss_n
);
    logic [DATA_W-1:0]  cmd_payload;
    logic [LEN_W-1:0]   cmd_width_m1;
    logic               cmd_release;
    logic               cmd_gap;
    logic [NUM_SEL-1:0] cmd_sel_mask;
    logic               first_half;
    logic               sample_now;
    logic               period_end;
    logic               run;
    logic               shifting;
    logic               tx_bit;
    logic               rx_bit_in;
    logic [NUM_SEL-1:0] sel_q;

    spim_word_decode #(.NUM_SEL(NUM_SEL)) u_decode (
        .word        (tx_word),
        .payload     (cmd_payload),
        .width_m1    (cmd_width_m1),
        .release_sel (cmd_release),
        .gap_after   (cmd_gap),
        .sel_mask    (cmd_sel_mask)
    );

    spim_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .div        (clk_div),
        .first_half (first_half),
        .sample_now (sample_now),
        .period_end (period_end)
    );

    spim_frame_ctrl #(.NUM_SEL(NUM_SEL)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .cfg_lsb_first (cfg_lsb_first),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .cmd_payload   (cmd_payload),
        .cmd_width_m1  (cmd_width_m1),
        .cmd_release   (cmd_release),
        .cmd_gap       (cmd_gap),
        .cmd_sel_mask  (cmd_sel_mask),
        .sample_now    (sample_now),
        .period_end    (period_end),
        .rx_bit_in     (rx_bit_in),
        .run           (run),
        .shifting      (shifting),
        .tx_bit        (tx_bit),
        .sel_q         (sel_q),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .rx_data       (rx_data),
        .rx_overrun    (rx_overrun)
    );

    // Serial clock: active in the second half of a bit for phase 0, in the first half for phase 1
    assign sck       = (shifting && enable) ? (cfg_cpol ^ (cfg_cpha ? first_half : ~first_half))
                                            : cfg_cpol;
    assign mosi      = tx_bit;
    // Receive source: outgoing bit in loopback, otherwise the input pin
    assign rx_bit_in = cfg_loopback ? tx_bit : miso;
    // Selects forced high while disabled
    assign ss_n      = enable ? sel_q : '1;
endmodule

// File: rtl/spim_frame_engine_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the SPI master frame engine,
// bound into every instance of the top module.
module spim_frame_engine_chk #(
    parameter int NUM_SEL = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               cfg_cpol,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic               rx_valid,
    input logic               rx_ready,
    input logic               rx_overrun,
    input logic               sck,
    input logic [NUM_SEL-1:0] ss_n
);
    // R5: a frame offers its item for a single cycle
    p_single_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("p_single_push_r5");

    // R9: the loss report is a one-cycle pulse
    p_overrun_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> !rx_overrun)
        else $error("p_overrun_pulse_r9");

    // R10: disabled engine keeps selects high, clock idle and pops nothing
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> ((ss_n == {NUM_SEL{1'b1}}) && (sck == cfg_cpol) && !tx_ready))
        else $error("p_disabled_quiet_r10");

    // R3: whenever a word could be popped the clock rests at its idle level
    p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (sck == cfg_cpol))
        else $error("p_idle_sck_r3");

    // R11: a pop is followed by a busy cycle
    p_pop_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready)
        else $error("p_pop_busy_r11");

    // R7: without a pop the selects can only change by being released
    p_sel_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$past(tx_valid && tx_ready) && (ss_n != $past(ss_n)))
        |-> (ss_n == {NUM_SEL{1'b1}}))
        else $error("p_sel_change_r7");
endmodule

bind spim_frame_engine spim_frame_engine_chk #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_cpol   (cfg_cpol),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun),
    .sck        (sck),
    .ss_n       (ss_n)
);

// File: tb/spim_frame_engine_tb.sv
`timescale 1ns/1ps
module spim_frame_engine_tb;
    localparam int NSEL = 4;

    typedef struct packed {
        logic [31:0] word;
        logic [15:0] pat;
        logic        cpol;
        logic        cpha;
        logic        lsb;
        logic        loop;
        logic [15:0] div;
    } vec_t;

    // word = {width-1[31:28], rsvd[27:26], gap[25], release[24], mask[23:16], payload[15:0]}
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h71FE00A5, 16'h00B4, 1'b0, 1'b0, 1'b0, 1'b0, 16'd3},
        '{32'hF1FD1234, 16'hC3A5, 1'b1, 1'b1, 1'b1, 1'b0, 16'd0},
        '{32'h01F70001, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1},
        '{32'hB1FE0ABC, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 16'd4},
        '{32'h83FB01FF, 16'h0155, 1'b0, 1'b0, 1'b1, 1'b0, 16'd2},
        '{32'h3DFEFFF6, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_loopback = 1'b0;
    logic [15:0] clk_div = 16'd1;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] tx_word = '0;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [15:0] rx_data;
    logic        rx_overrun;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic [NSEL-1:0] ss_n;

    int n_checks = 0;
    int n_fail   = 0;

    // monitor state
    logic [15:0]     cur_pat = '0;
    logic [15:0]     cap = '0;
    int              nsmp = 0;
    realtime         first_t, last_t;
    logic [NSEL-1:0] ss_first;
    logic            ss_var = 1'b0;
    logic [15:0]     rx_got = '0;
    int              rx_cnt = 0;
    int              ovr_cnt = 0;
    realtime         rx_t, rel_t;
    logic            rel_seen = 1'b1;

    always #2.5 clk = ~clk;

    spim_frame_engine #(.NUM_SEL(NSEL), .DIV_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_loopback(cfg_loopback), .clk_div(clk_div),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_overrun(rx_overrun),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // Slave model: capture mosi on each sampling edge, then present the next miso bit
    always @(sck) begin
        if (ss_n != {NSEL{1'b1}} && ((sck != cfg_cpol) != cfg_cpha)) begin
            if (nsmp < 16) cap[nsmp] = mosi;
            if (nsmp == 0) begin
                first_t  = $realtime;
                ss_first = ss_n;
            end else if (ss_n != ss_first) begin
                ss_var = 1'b1;
            end
            last_t = $realtime;
            nsmp   = nsmp + 1;
            if (nsmp < 16) miso = cur_pat[nsmp];
        end
    end

    // Receive-side monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid && rx_ready) begin
            rx_got   = rx_data;
            rx_cnt   = rx_cnt + 1;
            rx_t     = $realtime;
            rel_seen = 1'b0;
        end else if (!rel_seen && ss_n == {NSEL{1'b1}}) begin
            rel_t    = $realtime;
            rel_seen = 1'b1;
        end
        if (rx_overrun) ovr_cnt = ovr_cnt + 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mon(input logic [15:0] pat);
        cur_pat = pat;
        cap     = '0;
        nsmp    = 0;
        ss_var  = 1'b0;
        miso    = pat[0];
    endtask

    // Offer one word; returns at the negedge after it was popped
    task automatic push_word(input logic [31:0] w);
        tx_word  = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_item(input int rx0, input int ov0);
        int guard = 0;
        while (rx_cnt == rx0 && ovr_cnt == ov0 && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int          w, p, rx0;
        logic [15:0] exp_cap, exp_rx;
        w = int'(v.word[31:28]) + 1;
        p = (int'(v.div) + 1 < 2) ? 2 : int'(v.div) + 1;
        cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_lsb_first = v.lsb;
        cfg_loopback = v.loop; clk_div = v.div;
        @(negedge clk);
        clear_mon(v.pat);
        rx0 = rx_cnt;
        push_word(v.word);
        check("R11 tx_ready low while frame runs", {31'd0, tx_ready}, 32'd0);
        wait_item(rx0, ovr_cnt);
        repeat (p + 4) @(negedge clk);
        exp_cap = '0;
        exp_rx  = '0;
        for (int k = 0; k < w; k++) begin
            int pos = v.lsb ? k : (w - 1 - k);
            exp_cap[k]  = v.word[pos];
            exp_rx[pos] = v.loop ? v.word[pos] : v.pat[k];
        end
        check("R1 sample count equals width field+1", nsmp, w);
        check("R4 mosi bit order", {16'd0, cap}, {16'd0, exp_cap});
        if (v.loop) check("R6 loopback item", {16'd0, rx_got}, {16'd0, exp_rx});
        else        check("R5 received item", {16'd0, rx_got}, {16'd0, exp_rx});
        check("R5 one item per frame", rx_cnt - rx0, 1);
        if (w > 1) check("R2 sampling spacing in cycles", int'((last_t - first_t) / 5.0), (w - 1) * p);
        check("R7 selects during frame", {28'd0, ss_first}, {28'd0, v.word[19:16]});
        check("R7 selects stable in frame", {31'd0, ss_var}, 32'd0);
        if (v.word[25]) check("R8 gap before release", int'((rel_t - rx_t) / 5.0), p + 1);
        else            check("R7 release one cycle after item", int'((rel_t - rx_t) / 5.0), 1);
        check("R3 sck idle after frame", {31'd0, sck}, {31'd0, v.cpol});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int rx0, ov0;
        repeat (5) @(negedge clk);
        rst_n  = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        // reset state
        check("R7 selects high after reset", {28'd0, ss_n}, 32'hF);
        check("R3 sck idle after reset", {31'd0, sck}, 32'd0);
        check("R11 tx_ready idle after reset", {31'd0, tx_ready}, 32'd1);
        check("R5 no item after reset", {31'd0, rx_valid}, 32'd0);

        // table of frames
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: select held across an empty queue, then chained frame with release
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_loopback = 1'b0; clk_div = 16'd1;
        @(negedge clk);
        clear_mon(16'h0000);
        rx0 = rx_cnt;
        push_word(32'h30FE0009);
        wait_item(rx0, ovr_cnt);
        repeat (20) @(negedge clk);
        check("R7 select held with empty queue", {28'd0, ss_n}, 32'hE);
        check("R7 sck idle while held", {31'd0, sck}, 32'd0);
        check("R4 first held frame bits", {16'd0, cap}, 32'h9);
        clear_mon(16'h000F);
        push_word(32'h31FE0005);
        wait_item(rx0 + 1, ovr_cnt);
        repeat (6) @(negedge clk);
        check("R7 chained frame select", {28'd0, ss_first}, 32'hE);
        check("R7 chained frame select stable", {31'd0, ss_var}, 32'd0);
        check("R5 chained item", {16'd0, rx_got}, 32'hF);
        check("R7 release after chained frame", {28'd0, ss_n}, 32'hF);

        // R9: receive queue full at frame end
        clear_mon(16'h00FF);
        rx_ready = 1'b0;
        rx0 = rx_cnt; ov0 = ovr_cnt;
        push_word(32'h71FE0033);
        wait_item(rx0, ov0);
        repeat (4) @(negedge clk);
        check("R9 one overrun pulse", ovr_cnt - ov0, 1);
        check("R9 lost item not delivered", rx_cnt - rx0, 0);
        rx_ready = 1'b1;
        clear_mon(16'h0081);
        push_word(32'h71FE0044);
        wait_item(rx0, ov0 + 1);
        repeat (4) @(negedge clk);
        check("R9 next frame delivered", {16'd0, rx_got}, 32'h81);
        check("R9 no further overrun", ovr_cnt - ov0, 1);

        // R10: disable in mid-frame
        clk_div = 16'd9;
        @(negedge clk);
        clear_mon(16'h0000);
        rx0 = rx_cnt;
        push_word(32'hF1FE1234);
        repeat (40) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R10 selects high when disabled", {28'd0, ss_n}, 32'hF);
        check("R10 sck idle when disabled", {31'd0, sck}, 32'd0);
        tx_word  = 32'h71FE0055;
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 no pop when disabled", {31'd0, tx_ready}, 32'd0);
        tx_valid = 1'b0;
        repeat (200) @(negedge clk);
        check("R10 abandoned frame gives no item", rx_cnt - rx0, 0);
        enable = 1'b1;
        @(negedge clk);
        check("R11 ready after re-enable", {31'd0, tx_ready}, 32'd1);
        check("R10 selects high after re-enable", {28'd0, ss_n}, 32'hF);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule